// File: doc/BRIEF.md
# Coherence Transaction Tracking Table

This block sits at one node of a coherent multiprocessor and remembers every coherence transaction the node has in flight. Each entry is found by its line address: a read miss waiting for its data, or a dirty line the node has evicted and is writing back. Requests forwarded by the home arrive on the ordered lane. The answering data for the node's own misses arrives on the reply lane. The table ensures that every forwarded request it can match is eventually answered with data. None is refused or sent back for retry.

A forwarded request that finds its entry already holding data, either received for a miss or kept from a writeback, is answered from that copy. A forward that reaches a miss before that miss's data has come back is parked in the entry. It is answered once the reply fills the entry. A writeback copy stays until an explicit release arrives, so a forward that races the writeback still finds data. An ordering marker for the node's own request must arrive before a completed miss entry can be retired. When every entry is in use, new allocations are refused through a full flag, while lookups go on as normal.

Top module: `ttt_node`

## Requirements
- R1: After reset, `full`, `svc_vld` and `dup_err` are 0.
- R2: An allocation (`alloc_vld`=1, `alloc_wb`=1 for a writeback with data, 0 for a miss) takes the lowest-numbered free entry. `full` is 1 exactly when all entries are occupied. An allocation presented while `full` is 1 is dropped, and its address is not matched by later forwards.
- R3: A forward sampled at clock edge k for an entry that holds data is answered at edge k+1. The answer sets `svc_vld`=1 and carries the entry's address, the forward's `fwd_src` and the entry's data.
- R4: A forward for a miss entry still waiting for data produces no answer until a reply for that address is sampled, at edge k. The answer then appears at edge k+1 with the reply data and the parked requester.
- R5: A writeback entry answers any number of forwards from its kept copy. It is freed only by a release for its address, after which `full` drops and forwards to that address get no answer.
- R6: A release that arrives while a forward is parked in the entry, or together with a forward for that entry, is ignored, and the entry stays held.
- R7: A miss entry that has received its data is freed by a release only if an ordering marker for its address was sampled on an earlier edge. Without one, the release is ignored.
- R8: A forward that hits an entry whose earlier parked forward is still unanswered raises `dup_err` for one cycle, from the edge that samples it. The first requester stays the one that is answered.
- R9: A forward whose address matches no occupied entry produces no answer.
- R10: When several entries are ready to answer in the same cycle, one answer is produced per cycle, lowest entry number first.
- R11: A reply for an entry that is not waiting for data is ignored, and the entry keeps its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_vld | input | 1 | Allocate an entry this cycle |
| alloc_wb | input | 1 | 1 = writeback with data, 0 = miss |
| alloc_addr | input | AW | Line address of the new entry |
| alloc_data | input | DW | Writeback line data |
| full | output | 1 | All entries occupied |
| rsp_vld | input | 1 | Data reply lane valid |
| rsp_addr | input | AW | Reply line address |
| rsp_data | input | DW | Reply line data |
| fwd_vld | input | 1 | Forwarded request on ordered lane |
| fwd_addr | input | AW | Forwarded request address |
| fwd_src | input | SW | Requesting node of the forward |
| mrk_vld | input | 1 | Ordering marker on ordered lane |
| mrk_addr | input | AW | Marker address |
| rel_vld | input | 1 | Release (retire) request |
| rel_addr | input | AW | Release address |
| svc_vld | output | 1 | Forward answer valid |
| svc_addr | output | AW | Answered line address |
| svc_src | output | SW | Requester to receive the data |
| svc_data | output | DW | Line data sent to the requester |
| dup_err | output | 1 | Second forward to a parked entry |

## Verification
Every forward is parked on the edge that samples it, and the answer register loads on the next edge. An answer is therefore due two edges after a forward into a data-holding entry, or two edges after the reply that fills a waiting entry. The bench drives on falling edges and samples the answer at the falling edge after the second rising edge. For forwards that must stay unanswered, it checks `svc_vld` at that same point. `full` and `dup_err` depend only on registered state from the sampling edge, so they are checked at the falling edge right after it. The priority case presents a reply and a forward in the same cycle and expects the two answers on consecutive cycles.

// File: rtl/ttt_pkg.sv
package ttt_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RXD  = 2'd2,
    ST_VICT = 2'd3
  } ent_st_e;
endpackage

// File: rtl/ttt_match.sv
module ttt_match #(
  parameter int N  = 48,
  parameter int AW = 34
) (
  input  logic          en,
  input  logic [AW-1:0] key,
  input  logic [N-1:0]  live,
  input  logic [N*AW-1:0] tags,
  output logic [N-1:0]  hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = en & live[g] & (tags[g*AW +: AW] == key);
  end
endmodule

// File: rtl/ttt_pick.sv
module ttt_pick #(
  parameter int N  = 48,
  parameter int IW = 6
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any   = |req;
  assign grant = req & (~req + {{(N-1){1'b0}}, 1'b1});
endmodule

// File: rtl/ttt_node.sv
module ttt_node
  import ttt_pkg::*;
#(
  parameter int N_ENT = 48,
  parameter int AW    = 34,
  parameter int DW    = 512,
  parameter int SW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_vld,
  input  logic          alloc_wb,
  input  logic [AW-1:0] alloc_addr,
  input  logic [DW-1:0] alloc_data,
  output logic          full,
  input  logic          rsp_vld,
  input  logic [AW-1:0] rsp_addr,
  input  logic [DW-1:0] rsp_data,
  input  logic          fwd_vld,
  input  logic [AW-1:0] fwd_addr,
  input  logic [SW-1:0] fwd_src,
  input  logic          mrk_vld,
  input  logic [AW-1:0] mrk_addr,
  input  logic          rel_vld,
  input  logic [AW-1:0] rel_addr,
  output logic          svc_vld,
  output logic [AW-1:0] svc_addr,
  output logic [SW-1:0] svc_src,
  output logic [DW-1:0] svc_data,
  output logic          dup_err
);
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  // reset: asynchronous assertion, synchronous release
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  ent_st_e            st_q [N_ENT];
  ent_st_e            st_d [N_ENT];
  logic [N_ENT-1:0]   park_q, park_d, mark_q, mark_d;
  logic [SW-1:0]      src_q [N_ENT];
  logic [SW-1:0]      src_d [N_ENT];
  logic [DW-1:0]      dat_q [N_ENT];
  logic [N_ENT-1:0]   dat_we, dat_rsp;
  logic [N_ENT*AW-1:0] tag_q;
  logic [N_ENT-1:0]   live, ready;
  logic [N_ENT-1:0]   fwd_hit, rsp_hit, mrk_hit, rel_hit;
  logic [N_ENT-1:0]   free_g, srv_g;
  logic [IW-1:0]      free_idx, srv_idx;
  logic               free_any, srv_any, do_alloc, err_d;

  for (genvar g = 0; g < N_ENT; g++) begin : g_flags
    assign live[g]  = (st_q[g] != ST_FREE);
    assign ready[g] = park_q[g] & ((st_q[g] == ST_RXD) | (st_q[g] == ST_VICT));
  end

  ttt_match #(.N(N_ENT), .AW(AW)) u_m_fwd (.en(fwd_vld), .key(fwd_addr), .live(live), .tags(tag_q), .hit(fwd_hit));
  ttt_match #(.N(N_ENT), .AW(AW)) u_m_rsp (.en(rsp_vld), .key(rsp_addr), .live(live), .tags(tag_q), .hit(rsp_hit));
  ttt_match #(.N(N_ENT), .AW(AW)) u_m_mrk (.en(mrk_vld), .key(mrk_addr), .live(live), .tags(tag_q), .hit(mrk_hit));
  ttt_match #(.N(N_ENT), .AW(AW)) u_m_rel (.en(rel_vld), .key(rel_addr), .live(live), .tags(tag_q), .hit(rel_hit));

  ttt_pick #(.N(N_ENT), .IW(IW)) u_p_free (.req(~live), .any(free_any), .idx(free_idx), .grant(free_g));
  ttt_pick #(.N(N_ENT), .IW(IW)) u_p_srv  (.req(ready), .any(srv_any), .idx(srv_idx), .grant(srv_g));

  assign full     = ~free_any;
  assign do_alloc = alloc_vld & free_any;

  // next-state
  always_comb begin
    err_d = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      st_d[i]    = st_q[i];
      park_d[i]  = park_q[i];
      mark_d[i]  = mark_q[i];
      src_d[i]   = src_q[i];
      dat_we[i]  = 1'b0;
      dat_rsp[i] = 1'b0;
      if (srv_g[i]) park_d[i] = 1'b0;
      if (fwd_hit[i]) begin
        if (park_q[i] && !srv_g[i]) begin
          err_d = 1'b1;
        end else begin
          park_d[i] = 1'b1;
          src_d[i]  = fwd_src;
        end
      end
      if (mrk_hit[i] && (st_q[i] == ST_WAIT || st_q[i] == ST_RXD)) mark_d[i] = 1'b1;
      if (rsp_hit[i] && st_q[i] == ST_WAIT) begin
        st_d[i]    = ST_RXD;
        dat_we[i]  = 1'b1;
        dat_rsp[i] = 1'b1;
      end
      if (rel_hit[i] && !park_q[i] && !fwd_hit[i] &&
          (st_q[i] == ST_VICT || (st_q[i] == ST_RXD && mark_q[i]))) begin
        st_d[i]   = ST_FREE;
        mark_d[i] = 1'b0;
      end
      if (do_alloc && free_g[i]) begin
        st_d[i]   = alloc_wb ? ST_VICT : ST_WAIT;
        dat_we[i] = alloc_wb;
        mark_d[i] = 1'b0;
        park_d[i] = 1'b0;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      for (int i = 0; i < N_ENT; i++) st_q[i] <= ST_FREE;
      park_q  <= '0;
      mark_q  <= '0;
      svc_vld <= 1'b0;
      dup_err <= 1'b0;
    end else begin
      for (int i = 0; i < N_ENT; i++) st_q[i] <= st_d[i];
      park_q  <= park_d;
      mark_q  <= mark_d;
      svc_vld <= srv_any;
      dup_err <= err_d;
    end
  end

  // payload registers, enabled writes, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < N_ENT; i++) begin
      src_q[i] <= src_d[i];
      if (dat_we[i]) dat_q[i] <= dat_rsp[i] ? rsp_data : alloc_data;
    end
    if (do_alloc) tag_q[free_idx*AW +: AW] <= alloc_addr;
    if (srv_any) begin
      svc_addr <= tag_q[srv_idx*AW +: AW];
      svc_src  <= src_q[srv_idx];
      svc_data <= dat_q[srv_idx];
    end
  end
endmodule

// File: rtl/ttt_chk.sv
module ttt_chk #(
  parameter int N = 48
) (
  input logic         clk,
  input logic         rst_n,
  input logic         full,
  input logic         alloc_vld,
  input logic         rel_vld,
  input logic         fwd_vld,
  input logic         dup_err,
  input logic         svc_vld,
  input logic [N-1:0] live,
  input logic [N-1:0] park
);
  // R2: a refused allocation leaves the table full
  p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full && alloc_vld && !rel_vld |=> full);

  // R2: an accepted allocation occupies exactly one more entry
  p_alloc_adds_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !full && alloc_vld && !rel_vld |=> $countones(live) == $past($countones(live)) + 1);

  // R8: the error flag only follows a forward
  p_err_after_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |-> $past(fwd_vld));

  // R3: an answer is only produced for a parked forward
  p_svc_from_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
    svc_vld |-> $past(|park));

  // R6: a parked forward never sits in a freed entry
  p_park_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (park & ~live) == '0);
endmodule

bind ttt_node ttt_chk #(.N(N_ENT)) u_chk (
  .clk(clk), .rst_n(rst_s), .full(full), .alloc_vld(alloc_vld),
  .rel_vld(rel_vld), .fwd_vld(fwd_vld), .dup_err(dup_err),
  .svc_vld(svc_vld), .live(live), .park(park_q)
);

// File: tb/sim_ttt_node.sv
module sim_ttt_node;
  localparam int N = 4, AW = 8, DW = 16, SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_vld = 0, alloc_wb = 0, rsp_vld = 0, fwd_vld = 0, mrk_vld = 0, rel_vld = 0;
  logic [AW-1:0] alloc_addr = '0, rsp_addr = '0, fwd_addr = '0, mrk_addr = '0, rel_addr = '0;
  logic [DW-1:0] alloc_data = '0, rsp_data = '0;
  logic [SW-1:0] fwd_src = '0;
  logic full, svc_vld, dup_err;
  logic [AW-1:0] svc_addr;
  logic [SW-1:0] svc_src;
  logic [DW-1:0] svc_data;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ttt_node #(.N_ENT(N), .AW(AW), .DW(DW), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_vld(alloc_vld), .alloc_wb(alloc_wb),
    .alloc_addr(alloc_addr), .alloc_data(alloc_data), .full(full),
    .rsp_vld(rsp_vld), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .fwd_vld(fwd_vld), .fwd_addr(fwd_addr), .fwd_src(fwd_src),
    .mrk_vld(mrk_vld), .mrk_addr(mrk_addr), .rel_vld(rel_vld), .rel_addr(rel_addr),
    .svc_vld(svc_vld), .svc_addr(svc_addr), .svc_src(svc_src), .svc_data(svc_data),
    .dup_err(dup_err)
  );

  function automatic logic [DW-1:0] wdat(input logic [AW-1:0] a);
    return {a, a ^ 8'h5A};
  endfunction
  function automatic logic [DW-1:0] rdat(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic alloc(input logic [AW-1:0] a, input logic wb);
    alloc_vld = 1; alloc_wb = wb; alloc_addr = a; alloc_data = wdat(a);
    @(negedge clk);
    alloc_vld = 0;
  endtask
  task automatic fwd(input logic [AW-1:0] a, input logic [SW-1:0] s);
    fwd_vld = 1; fwd_addr = a; fwd_src = s;
    @(negedge clk);
    fwd_vld = 0;
  endtask
  task automatic rsp(input logic [AW-1:0] a, input logic [DW-1:0] d);
    rsp_vld = 1; rsp_addr = a; rsp_data = d;
    @(negedge clk);
    rsp_vld = 0;
  endtask
  task automatic mrk(input logic [AW-1:0] a);
    mrk_vld = 1; mrk_addr = a;
    @(negedge clk);
    mrk_vld = 0;
  endtask
  task automatic rel(input logic [AW-1:0] a);
    rel_vld = 1; rel_addr = a;
    @(negedge clk);
    rel_vld = 0;
  endtask
  task automatic exp_svc(input string tag, input logic [AW-1:0] a,
                         input logic [SW-1:0] s, input logic [DW-1:0] d);
    @(negedge clk);
    chk({tag, " svc_vld"}, svc_vld, 1);
    chk({tag, " svc_addr"}, svc_addr, a);
    chk({tag, " svc_src"}, svc_src, s);
    chk({tag, " svc_data"}, svc_data, d);
  endtask
  task automatic exp_none(input string tag);
    @(negedge clk);
    chk({tag, " no answer"}, svc_vld, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 full", full, 0);
    chk("R1 svc_vld", svc_vld, 0);
    chk("R1 dup_err", dup_err, 0);

    // R2 / R5: fill with writebacks, then sweep forwards over every entry
    for (int i = 0; i < N; i++) begin
      alloc(8'h10 + 8'(i), 1'b1);
      chk("R2 full while filling", full, (i == N - 1));
    end
    alloc(8'h20, 1'b1);
    fwd(8'h20, 4'h1);
    exp_none("R2 dropped alloc");
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < N; i++) begin
        fwd(8'h10 + 8'(i), SW'(i + r));
        exp_svc("R5 victim copy", 8'h10 + 8'(i), SW'(i + r), wdat(8'h10 + 8'(i)));
      end
    end
    rel(8'h12);
    chk("R5 full after release", full, 0);
    fwd(8'h12, 4'h3);
    exp_none("R5 released line");
    alloc(8'h30, 1'b1);
    chk("R2 refill", full, 1);

    // R4 / R8 / R11 / R7 / R9 on a miss
    do_reset();
    alloc(8'h40, 1'b0);
    fwd(8'h40, 4'h3);
    exp_none("R4 parked");
    exp_none("R4 still parked");
    fwd(8'h40, 4'h5);
    chk("R8 dup_err", dup_err, 1);
    @(negedge clk);
    chk("R8 dup_err pulse", dup_err, 0);
    rsp(8'h40, rdat(8'h40));
    exp_svc("R4 R8 reply wakes parked", 8'h40, 4'h3, rdat(8'h40));
    rsp(8'h40, 16'hBEEF);
    fwd(8'h40, 4'h7);
    exp_svc("R11 stale reply ignored", 8'h40, 4'h7, rdat(8'h40));
    fwd(8'h77, 4'h2);
    exp_none("R9 unmatched forward");
    rel(8'h40);
    fwd(8'h40, 4'h2);
    exp_svc("R7 release before marker", 8'h40, 4'h2, rdat(8'h40));
    mrk(8'h40);
    rel(8'h40);
    fwd(8'h40, 4'h2);
    exp_none("R7 release after marker");

    // R6: release racing a parked forward
    do_reset();
    alloc(8'h50, 1'b1);
    fwd_vld = 1; fwd_addr = 8'h50; fwd_src = 4'h4;
    rel_vld = 1; rel_addr = 8'h50;
    @(negedge clk);
    fwd_vld = 0;
    @(negedge clk);
    rel_vld = 0;
    chk("R6 svc_vld", svc_vld, 1);
    chk("R6 svc_data", svc_data, wdat(8'h50));
    fwd(8'h50, 4'h6);
    exp_svc("R6 entry kept", 8'h50, 4'h6, wdat(8'h50));
    rel(8'h50);
    fwd(8'h50, 4'h6);
    exp_none("R5 R6 freed by release");

    // R10: two entries ready in the same cycle
    do_reset();
    alloc(8'h60, 1'b1);
    alloc(8'h61, 1'b0);
    fwd(8'h61, 4'h1);
    rsp_vld = 1; rsp_addr = 8'h61; rsp_data = rdat(8'h61);
    fwd_vld = 1; fwd_addr = 8'h60; fwd_src = 4'h0;
    @(negedge clk);
    rsp_vld = 0; fwd_vld = 0;
    exp_svc("R10 lower entry first", 8'h60, 4'h0, wdat(8'h60));
    exp_svc("R10 higher entry next", 8'h61, 4'h1, rdat(8'h61));
    exp_none("R10 one answer each");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule